// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Processor

This block computes the effective address that an 8-bit processor's load and store instructions use. When the surrounding core has decoded an instruction, it pulses `start` while it holds the addressing-mode code, the two index registers and the address of the opcode. The block then reads the operand bytes that follow the opcode through a simple synchronous byte-read port. For the two indirect modes it also reads a two-byte pointer from page zero. It returns the 16-bit effective address, the program counter advanced past the instruction, and a page-cross flag.

Arithmetic on page-zero addresses wraps within page zero, and so do pointer fetches. Indexed full-width addresses carry into the high byte and wrap modulo 65536. Opcode decode, the data access itself and cycle-exact dummy reads belong to other blocks.

Top module: `ea_gen`

## Requirements
- R1: `start` is sampled only while `busy` is low. The mode, both index values and the program counter are captured on that edge and `busy` rises. A `start` seen while `busy` is high has no effect on the running computation.
- R2: Mode code 0 (immediate) yields `effAddr` = `pcIn`+1 and `pcOut` = `pcIn`+2 and performs no memory read. Codes 9 to 15 behave the same way.
- R3: Mode code 1 (page zero) reads one operand byte at `pcIn`+1 and yields `effAddr` = {8'h00, operand} and `pcOut` = `pcIn`+2.
- R4: Mode codes 2 and 3 (page zero indexed by X and by Y) add the index to the operand modulo 256, so the high byte of `effAddr` is always 8'h00. `pcOut` = `pcIn`+2.
- R5: Mode code 4 (absolute) reads the low byte at `pcIn`+1 and the high byte at `pcIn`+2. It yields `effAddr` = {high, low} and `pcOut` = `pcIn`+3.
- R6: Mode codes 5 and 6 (absolute indexed by X and by Y) add the zero-extended index to {high, low} modulo 65536. `pageCross` is 1 exactly when the high byte of the sum differs from the high byte of the base. `pcOut` = `pcIn`+3.
- R7: Mode code 7 (indexed indirect) forms p = (operand + X) mod 256. It reads the pointer low byte at {8'h00, p} and the high byte at {8'h00, (p+1) mod 256}, and the pointer is the effective address. `pcOut` = `pcIn`+2.
- R8: Mode code 8 (indirect indexed) reads the pointer low byte at {8'h00, operand} and the high byte at {8'h00, (operand+1) mod 256}. It yields pointer + Y modulo 65536, with `pageCross` as in R6. `pcOut` = `pcIn`+2.
- R9: `done` is high for exactly one cycle, and `effAddr`, `pcOut` and `pageCross` are valid while it is high. Read data is expected one cycle after the address is presented. The number of clock edges from the edge that samples `start` until `done` is high is 2 for immediate, 3 for the page-zero modes, 4 for the absolute modes and 5 for the indirect modes.
- R10: `pageCross` is 0 for every mode other than 5, 6 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (sampled when idle) |
| mode | input | 4 | Addressing-mode code |
| idxX | input | 8 | X index register value |
| idxY | input | 8 | Y index register value |
| pcIn | input | 16 | Address of the opcode byte |
| memAddr | output | 16 | Byte-read address |
| memRd | output | 1 | Read strobe for memAddr |
| memData | input | 8 | Read data, valid the cycle after the strobe |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| effAddr | output | 16 | Effective address |
| pcOut | output | 16 | Program counter past the instruction |
| pageCross | output | 1 | Indexed addition changed the high byte |

## Verification
Every mode is driven from a table of operand locations. The memory returns a known pattern, so each operand and pointer byte differs from its neighbours, which would show a swapped low/high order or a read at the wrong address. For each mode, index values that stay inside a page are set against values that overflow the low byte. The overflowing values separate wrap-in-page-zero from carry-into-high-byte, and they also exercise the page-cross flag and the 65536 wrap. One case has the pointer at 8'hFF, which shows whether the second pointer fetch wraps to address 0. Directed cases cover the reset values, a `start` issued while busy, and the exact count of reads and cycles per mode.

// File: rtl/eag_pkg.sv
package eag_pkg;
  parameter int ADDR_W = 16;
  parameter int BYTE_W = 8;

  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_ZP   = 4'd1,
    AM_ZPX  = 4'd2,
    AM_ZPY  = 4'd3,
    AM_ABS  = 4'd4,
    AM_ABSX = 4'd5,
    AM_ABSY = 4'd6,
    AM_INDX = 4'd7,
    AM_INDY = 4'd8
  } amode_e;

  typedef enum logic [1:0] {K_IMM, K_ZP, K_ABS, K_IND} akind_e;

  typedef enum logic [1:0] {RD_NONE, RD_PC, RD_ZPNEW, RD_PTRHI} rdsel_e;

  typedef struct packed {
    logic   latch;
    logic   incPc;
    logic   capImm;
    logic   capLo;
    logic   capHi;
    logic   capPtr;
    logic   finish;
    rdsel_e rdSel;
  } ctrl_t;

  function automatic akind_e modeKind(input logic [3:0] m);
    case (m)
      AM_ZP, AM_ZPX, AM_ZPY:   modeKind = K_ZP;
      AM_ABS, AM_ABSX, AM_ABSY: modeKind = K_ABS;
      AM_INDX, AM_INDY:         modeKind = K_IND;
      default:                  modeKind = K_IMM;
    endcase
  endfunction
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] modeIn,
  input  logic [3:0] modeQ,
  output ctrl_t      ctl,
  output logic       busy
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_IMM, ST_OPRD, ST_OPGET, ST_HIGET, ST_PLO, ST_PHI, ST_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    ctl.rdSel = RD_NONE;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.latch = 1'b1;
          stateNext = (modeKind(modeIn) == K_IMM) ? ST_IMM : ST_OPRD;
        end
      end
      ST_IMM: begin
        ctl.capImm = 1'b1;
        ctl.incPc  = 1'b1;
        stateNext  = ST_DONE;
      end
      ST_OPRD: begin
        ctl.rdSel = RD_PC;
        ctl.incPc = 1'b1;
        stateNext = ST_OPGET;
      end
      ST_OPGET: begin
        ctl.capLo = 1'b1;
        case (modeKind(modeQ))
          K_ABS: begin
            ctl.rdSel = RD_PC;
            ctl.incPc = 1'b1;
            stateNext = ST_HIGET;
          end
          K_IND: begin
            ctl.capPtr = 1'b1;
            ctl.rdSel  = RD_ZPNEW;
            stateNext  = ST_PLO;
          end
          default: stateNext = ST_DONE;
        endcase
      end
      ST_HIGET: begin
        ctl.capHi = 1'b1;
        stateNext = ST_DONE;
      end
      ST_PLO: begin
        ctl.capLo = 1'b1;
        ctl.rdSel = RD_PTRHI;
        stateNext = ST_PHI;
      end
      ST_PHI: begin
        ctl.capHi = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE: begin
        ctl.finish = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R9: result pulse lasts a single cycle
  a_r9_single_done: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> !ctl.finish);

  // R1: an accepted start makes the unit busy on the next cycle
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R1: capture strobes never fire while a computation runs
  a_r1_no_relatch: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.latch);
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [3:0]        modeIn,
  input  logic [BYTE_W-1:0] idxX,
  input  logic [BYTE_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] memData,
  output logic [3:0]        modeQ,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pageCross
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic [BYTE_W-1:0] xQ, yQ, loQ, hiQ, ptrQ, zpNew, idxSel, zpSum;
  logic [ADDR_W-1:0] pcQ, baseAddr, idxSum;
  logic              indexed16;

  assign zpNew = memData + ((modeQ == AM_INDX) ? xQ : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      xQ    <= '0;
      yQ    <= '0;
      pcQ   <= '0;
      loQ   <= '0;
      hiQ   <= '0;
      ptrQ  <= '0;
    end else begin
      if (ctl.latch) begin
        modeQ <= modeIn;
        xQ    <= idxX;
        yQ    <= idxY;
        pcQ   <= pcIn + ADDR_W'(1);
        loQ   <= '0;
        hiQ   <= '0;
      end else if (ctl.incPc) begin
        pcQ <= pcQ + ADDR_W'(1);
      end
      if (ctl.capImm) {hiQ, loQ} <= pcQ;
      if (ctl.capLo)  loQ  <= memData;
      if (ctl.capHi)  hiQ  <= memData;
      if (ctl.capPtr) ptrQ <= zpNew;
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_ZPNEW: memAddr = {{HI_W{1'b0}}, zpNew};
      RD_PTRHI: memAddr = {{HI_W{1'b0}}, ptrQ + BYTE_W'(1)};
      default:  memAddr = pcQ;
    endcase
  end
  assign memRd = (ctl.rdSel != RD_NONE);

  assign idxSel   = (modeQ == AM_ZPX || modeQ == AM_ABSX) ? xQ : yQ;
  assign baseAddr = {hiQ, loQ};
  assign idxSum   = baseAddr + {{HI_W{1'b0}}, idxSel};
  assign zpSum    = loQ + idxSel;
  assign indexed16 = (modeQ == AM_ABSX) || (modeQ == AM_ABSY) || (modeQ == AM_INDY);

  always_comb begin
    case (modeQ)
      AM_ZP:                     effAddr = {{HI_W{1'b0}}, loQ};
      AM_ZPX, AM_ZPY:            effAddr = {{HI_W{1'b0}}, zpSum};
      AM_ABSX, AM_ABSY, AM_INDY: effAddr = idxSum;
      default:                   effAddr = baseAddr;
    endcase
  end

  assign pageCross = indexed16 && (idxSum[ADDR_W-1:BYTE_W] != hiQ);
  assign pcOut     = pcQ;

  // R4: page-zero results stay in page zero
  a_r4_zp_result_page0: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && modeKind(modeQ) == K_ZP) |-> (effAddr[ADDR_W-1:BYTE_W] == '0));

  // R10: no page-cross indication for non-indexed modes
  a_r10_cross_only_indexed: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && pageCross) |-> indexed16);

  // R7: pointer fetches address page zero
  a_r7_ptr_in_page0: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && (ctl.rdSel == RD_ZPNEW || ctl.rdSel == RD_PTRHI))
      |-> (memAddr[ADDR_W-1:BYTE_W] == '0));

  // R5: each operand fetch moves the program counter by one
  a_r5_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdSel == RD_PC) |=> (pcOut == $past(memAddr) + ADDR_W'(1)));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  idxX,
  input  logic [7:0]  idxY,
  input  logic [15:0] pcIn,
  output logic [15:0] memAddr,
  output logic        memRd,
  input  logic [7:0]  memData,
  output logic        busy,
  output logic        done,
  output logic [15:0] effAddr,
  output logic [15:0] pcOut,
  output logic        pageCross
);
  ctrl_t      ctl;
  logic [3:0] modeQ;

  eag_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .modeIn (mode),
    .modeQ  (modeQ),
    .ctl    (ctl),
    .busy   (busy)
  );

  eag_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .modeIn    (mode),
    .idxX      (idxX),
    .idxY      (idxY),
    .pcIn      (pcIn),
    .memData   (memData),
    .modeQ     (modeQ),
    .memAddr   (memAddr),
    .memRd     (memRd),
    .effAddr   (effAddr),
    .pcOut     (pcOut),
    .pageCross (pageCross)
  );

  assign done = ctl.finish;
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  idxX = '0, idxY = '0;
  logic [15:0] pcIn = '0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memData = '0;
  logic        busy, done, pageCross;
  logic [15:0] effAddr, pcOut;

  int total = 0;
  int bad   = 0;
  int rdCnt = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .idxX(idxX), .idxY(idxY),
    .pcIn(pcIn), .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .busy(busy), .done(done), .effAddr(effAddr), .pcOut(pcOut), .pageCross(pageCross)
  );

  // Bench memory: code page 8'h80 returns the low address byte, else a pattern.
  function automatic logic [7:0] memFn(input logic [15:0] a);
    if (a[15:8] == 8'h80) return a[7:0];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_ff @(posedge clk) begin
    if (memRd) begin
      memData <= memFn(memAddr);
      rdCnt   <= rdCnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {mode, X, Y, pc}
  localparam logic [35:0] VECS [0:13] = '{
    {4'd0, 8'h00, 8'h00, 16'h8010},  // R2 immediate
    {4'd1, 8'h00, 8'h00, 16'h8020},  // R3 page zero
    {4'd2, 8'h10, 8'h00, 16'h8030},  // R4 zp,X no wrap
    {4'd2, 8'hF0, 8'h00, 16'h8040},  // R4 zp,X wrap
    {4'd3, 8'h00, 8'hE0, 16'h8050},  // R4 zp,Y wrap
    {4'd4, 8'h00, 8'h00, 16'h8060},  // R5 absolute
    {4'd5, 8'h05, 8'h00, 16'h8070},  // R6 abs,X same page
    {4'd5, 8'hA0, 8'h00, 16'h80F0},  // R6 abs,X page cross
    {4'd6, 8'h00, 8'h20, 16'h80FD},  // R6 abs,Y wrap past 16'hFFFF
    {4'd7, 8'h04, 8'h00, 16'h8020},  // R7 indexed indirect
    {4'd7, 8'h0E, 8'h00, 16'h80F0},  // R7 pointer at 8'hFF wraps
    {4'd8, 8'h00, 8'h05, 16'h8040},  // R8 indirect indexed
    {4'd8, 8'h00, 8'hB0, 16'h80FE},  // R8 pointer at 8'hFF, page cross
    {4'd12, 8'h33, 8'h44, 16'h8010}  // R2 unused code as immediate
  };

  function automatic string reqOf(input logic [3:0] m);
    case (m)
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic model(input logic [3:0] m, input logic [7:0] x, input logic [7:0] y,
                       input logic [15:0] pc, output logic [15:0] ea, output logic [15:0] npc,
                       output logic pcx, output int lat, output int nrd);
    logic [7:0]  op, op2, p;
    logic [15:0] base;
    op  = memFn(pc + 16'd1);
    op2 = memFn(pc + 16'd2);
    pcx = 1'b0;
    case (m)
      4'd1, 4'd2, 4'd3: begin
        p   = op + ((m == 4'd2) ? x : (m == 4'd3) ? y : 8'h00);
        ea  = {8'h00, p}; npc = pc + 16'd2; lat = 3; nrd = 1;
      end
      4'd4, 4'd5, 4'd6: begin
        base = {op2, op};
        ea   = base + {8'h00, (m == 4'd5) ? x : (m == 4'd6) ? y : 8'h00};
        pcx  = (m != 4'd4) && (ea[15:8] != base[15:8]);
        npc  = pc + 16'd3; lat = 4; nrd = 2;
      end
      4'd7, 4'd8: begin
        p    = (m == 4'd7) ? op + x : op;
        base = {memFn({8'h00, p + 8'd1}), memFn({8'h00, p})};
        ea   = (m == 4'd8) ? base + {8'h00, y} : base;
        pcx  = (m == 4'd8) && (ea[15:8] != base[15:8]);
        npc  = pc + 16'd2; lat = 5; nrd = 3;
      end
      default: begin
        ea = pc + 16'd1; npc = pc + 16'd2; lat = 2; nrd = 0;
      end
    endcase
  endtask

  task automatic runOne(input logic [3:0] m, input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] pc, output int lat);
    @(negedge clk);
    rdCnt = 0;
    mode = m; idxX = x; idxY = y; pcIn = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    logic [15:0] eaE, pcE;
    logic        pcxE;
    int          latE, nrdE, lat;

    repeat (3) @(negedge clk);
    // R1 / R9: reset state
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R9 done after reset", 32'(done), 32'd0);
    chk("R1 memRd after reset", 32'(memRd), 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < 14; i++) begin
      model(VECS[i][35:32], VECS[i][31:24], VECS[i][23:16], VECS[i][15:0],
            eaE, pcE, pcxE, latE, nrdE);
      runOne(VECS[i][35:32], VECS[i][31:24], VECS[i][23:16], VECS[i][15:0], lat);
      chk({reqOf(VECS[i][35:32]), " effAddr"}, 32'(effAddr), 32'(eaE));
      chk({reqOf(VECS[i][35:32]), " pcOut"}, 32'(pcOut), 32'(pcE));
      chk({reqOf(VECS[i][35:32]), " R10 pageCross"}, 32'(pageCross), 32'(pcxE));
      chk({reqOf(VECS[i][35:32]), " reads"}, 32'(rdCnt), 32'(nrdE));
      chk("R9 latency", 32'(lat), 32'(latE));
      @(negedge clk);
      chk("R9 done pulse width", 32'(done), 32'd0);
    end

    // R1: start while busy is ignored
    @(negedge clk);
    mode = 4'd1; idxX = 8'h00; idxY = 8'h00; pcIn = 16'h8020; start = 1'b1;
    @(negedge clk);
    mode = 4'd4; pcIn = 16'h8060; idxX = 8'h77;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R1 ignored start effAddr", 32'(effAddr), 32'h0021);
    chk("R1 ignored start pcOut", 32'(pcOut), 32'h8022);
    chk("R1 ignored start latency", 32'(lat), 32'd3);
    begin
      int extra = 0;
      repeat (6) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R1 no second result", 32'(extra), 32'd0);
      chk("R1 idle afterwards", 32'(busy), 32'd0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule